// File: doc/BRIEF.md
# Programmable Clock Phase Delay Generator

This block derives two phase-shifted copies of a divided module clock, typically one used to sample incoming data and one used to launch outgoing data on a card interface. The divider runs elsewhere. Its output reaches this block as a level that changes in step with the fast parent clock. The block delays that level by a whole number of parent-clock periods. Because the module clock is an integer division of the parent clock, this count is the finest phase step the block can produce.

Each output has a small code field inside a shared control word. A code of zero does not mean "no delay". It selects the inverted module clock, which gives a half-cycle (180 degree) shift. A nonzero code d delays the module clock by d parent periods, so with a divide ratio N the phase is about d times 360/N degrees. Software converts degrees to a code. A new code is adopted only at a module-clock rising edge, so a change of code cannot create a runt pulse partway through a module-clock cycle.

Top module: `phdly_gen`

## Requirements
- R1: While `rst_i` is high, every bit of `phase_o` is 0 after each parent-clock edge, and both adopted codes return to 0.
- R2: The code for output 0 is `ctrl_i[9:8]` and the code for output 1 is `ctrl_i[21:20]`. Bits [11:10] and [23:22] are reserved space in each field's 4-bit region and are ignored, as is every other bit of `ctrl_i`.
- R3: When an output's adopted code is 0, after parent edge k the output equals the inverse of `mod_clk_i` as sampled at edge k.
- R4: When an output's adopted code is d (1 to 3), after parent edge k the output equals `mod_clk_i` as sampled at edge k-d. Every module-clock edge therefore reaches the output d parent cycles later than under code 0.
- R5: A code is adopted only at a parent edge where `mod_clk_i` is sampled high after being sampled low at the previous edge. The output value produced at that edge still uses the previously adopted code.
- R6: After reset and until the first module-clock rising edge, both outputs behave as code 0, whatever `ctrl_i` holds.
- R7: The two outputs adopt and apply their codes independently. Changing one field never alters the other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast parent clock that also feeds the external divider |
| rst_i | input | 1 | Synchronous active-high reset |
| mod_clk_i | input | 1 | Divided module clock, a level synchronous to `clk_i` |
| ctrl_i | input | 32 | Control word holding both delay fields |
| phase_o | output | 2 | Registered phase-shifted clocks, bit i for output i |

## Verification
The checks assume that `mod_clk_i` is a level produced in the parent-clock domain, changing only between rising edges of `clk_i`. They also assume it is held low throughout reset, so that the block's history of the module clock and the checker's view of it agree from the first cycle after reset. The bench meets both conditions by driving `mod_clk_i`, `ctrl_i` and `rst_i` only on falling edges of `clk_i`, by keeping the module clock low for the whole reset interval, and by generating module-clock waveforms whose high time is the divide ratio halved and rounded down. The control word is allowed to change at any falling edge, including partway through a module-clock high phase, since adoption at the rising edge is itself under test.

// File: rtl/phdly_pkg.sv
package phdly_pkg;
  // Width of each delay code read from the control word.
  localparam int CODE_W       = 2;
  // Bit position of output 0's field and spacing to the next output's field.
  localparam int FIELD_BASE   = 8;
  localparam int FIELD_STRIDE = 12;
  // Longest delay that a code can select, in parent-clock periods.
  localparam int MAX_DLY      = (1 << CODE_W) - 1;
endpackage

// File: rtl/phdly_tap_line.sv
// Shared history of the module clock. taps[j] holds the value sampled j
// parent edges before the current one; taps[0] is the live input.
module phdly_tap_line #(
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             mck_i,
  output logic [DEPTH:0]   taps_o
);
  logic [DEPTH-1:0] hist_q;

  assign taps_o = {hist_q, mck_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q <= '0;
    end else begin
      hist_q <= taps_o[DEPTH-1:0];
    end
  end
endmodule

// File: rtl/phdly_code_hold.sv
// Holds the code an output currently applies; reloads only on request.
module phdly_code_hold #(
  parameter int CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_o <= '0;
    end else if (load_i) begin
      code_o <= code_i;
    end
  end
endmodule

// File: rtl/phdly_out_sel.sv
// Picks one tap (or the inverted live sample for code 0) and registers it.
module phdly_out_sel #(
  parameter int CODE_W = 2,
  localparam int NTAP  = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [NTAP-1:0]   taps_i,
  output logic              phase_o
);
  logic nxt;

  always_comb begin
    if (code_i == '0) begin
      nxt = ~taps_i[0];
    end else begin
      nxt = taps_i[code_i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_o <= 1'b0;
    end else begin
      phase_o <= nxt;
    end
  end
endmodule

// File: rtl/phdly_gen.sv
module phdly_gen #(
  parameter int NUM_OUT      = 2,
  parameter int REG_W        = 32,
  parameter int CODE_W       = phdly_pkg::CODE_W,
  parameter int FIELD_BASE   = phdly_pkg::FIELD_BASE,
  parameter int FIELD_STRIDE = phdly_pkg::FIELD_STRIDE
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               mod_clk_i,
  input  logic [REG_W-1:0]   ctrl_i,
  output logic [NUM_OUT-1:0] phase_o
);
  localparam int DEPTH = (1 << CODE_W) - 1;

  logic [DEPTH:0]                   taps;
  logic                             mck_rise;
  logic [NUM_OUT-1:0][CODE_W-1:0]   act_code;
  logic                             ctrl_unused;

  // Fields take only the low CODE_W bits of their region; the rest is ignored.
  assign ctrl_unused = ^ctrl_i;

  phdly_tap_line #(.DEPTH(DEPTH)) u_taps (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .mck_i  (mod_clk_i),
    .taps_o (taps)
  );

  // Rising edge of the module clock as seen in the parent domain.
  assign mck_rise = taps[0] & ~taps[1];

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_ch
    localparam int LSB = FIELD_BASE + FIELD_STRIDE * ch;
    logic [CODE_W-1:0] code_q;

    phdly_code_hold #(.CODE_W(CODE_W)) u_hold (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (mck_rise),
      .code_i (ctrl_i[LSB +: CODE_W]),
      .code_o (code_q)
    );

    assign act_code[ch] = code_q;

    phdly_out_sel #(.CODE_W(CODE_W)) u_sel (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .code_i  (code_q),
      .taps_i  (taps),
      .phase_o (phase_o[ch])
    );
  end
endmodule

// File: rtl/phdly_gen_chk.sv
module phdly_gen_chk #(
  parameter int NUM_OUT      = 2,
  parameter int REG_W        = 32,
  parameter int CODE_W       = 2,
  parameter int FIELD_BASE   = 8,
  parameter int FIELD_STRIDE = 12
) (
  input logic                           clk_i,
  input logic                           rst_i,
  input logic                           mod_clk_i,
  input logic [REG_W-1:0]               ctrl_i,
  input logic [NUM_OUT-1:0][CODE_W-1:0] act_code,
  input logic [NUM_OUT-1:0]             phase_o
);
  localparam int MAXD = (1 << CODE_W) - 1;

  // Edges seen since reset was released, saturating at the longest delay.
  logic [CODE_W:0] cyc;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cyc <= '0;
    end else if (cyc != (CODE_W+1)'(MAXD)) begin
      cyc <= cyc + 1'b1;
    end
  end

  // R1: outputs cleared by reset
  a_r1_reset_low: assert property (@(posedge clk_i) rst_i |=> phase_o == '0);

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_ch
    localparam int LSB = FIELD_BASE + FIELD_STRIDE * ch;

    // R5 / R2: adoption at a module-clock rise, from the channel's own field
    a_r5_load: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc != '0 && mod_clk_i && !$past(mod_clk_i))
        |=> act_code[ch] == $past(ctrl_i[LSB +: CODE_W]));

    // R5: no change of code away from a module-clock rise
    a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc != '0 && !(mod_clk_i && !$past(mod_clk_i))) |=> $stable(act_code[ch]));

    // R3: code 0 inverts the sampled module clock
    a_r3_invert: assert property (@(posedge clk_i) disable iff (rst_i)
      (act_code[ch] == '0) |=> phase_o[ch] == !$past(mod_clk_i));

    for (genvar d = 1; d <= MAXD; d++) begin : g_d
      // R4: code d delays by d parent cycles
      a_r4_delay: assert property (@(posedge clk_i) disable iff (rst_i)
        (cyc >= (CODE_W+1)'(d) && act_code[ch] == CODE_W'(d))
          |=> phase_o[ch] == $past(mod_clk_i, d + 1));
    end
  end
endmodule

bind phdly_gen phdly_gen_chk #(
  .NUM_OUT(NUM_OUT), .REG_W(REG_W), .CODE_W(CODE_W),
  .FIELD_BASE(FIELD_BASE), .FIELD_STRIDE(FIELD_STRIDE)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .mod_clk_i (mod_clk_i),
  .ctrl_i    (ctrl_i),
  .act_code  (act_code),
  .phase_o   (phase_o)
);

// File: tb/phdly_gen_tb_top.sv
`timescale 1ns/1ps
module phdly_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mck = 1'b0;
  logic [31:0] ctrl = '0;
  logic [1:0]  phase;

  int checks = 0;
  int fails  = 0;
  logic [7:0] hist = '0;
  logic [1:0] exp_code [2];
  string tag = "";

  always #2 clk = ~clk;   // 250 MHz

  phdly_gen dut_i (
    .clk_i(clk), .rst_i(rst), .mod_clk_i(mck), .ctrl_i(ctrl), .phase_o(phase)
  );

  // Module-clock value seen at each parent edge: hist[j] is edge k-j.
  always @(posedge clk) hist <= {hist[6:0], mck};

  // ratio[12:5], code0[4:3], code1[2:1], fill reserved/other bits[0]
  localparam logic [12:0] VECS [10] = '{
    {8'd4, 2'd1, 2'd2, 1'b0}, {8'd4, 2'd3, 2'd0, 1'b0},
    {8'd5, 2'd2, 2'd1, 1'b1}, {8'd8, 2'd0, 2'd3, 1'b0},
    {8'd6, 2'd1, 2'd1, 1'b1}, {8'd3, 2'd3, 2'd2, 1'b0},
    {8'd2, 2'd0, 2'd1, 1'b0}, {8'd7, 2'd2, 2'd0, 1'b1},
    {8'd9, 2'd3, 2'd3, 1'b0}, {8'd4, 2'd0, 2'd0, 1'b1}
  };

  function automatic logic [31:0] mk_ctrl(input logic [1:0] c0, input logic [1:0] c1,
                                          input logic fill);
    logic [31:0] w;
    w = fill ? 32'hFFFF_FFFF : 32'h0;
    w[9:8]   = c0;
    w[21:20] = c1;
    return w;
  endfunction

  task automatic chk(input string t, input int ch, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s out%0d: actual %b expected %b at %0t", t, ch, act, expv, $time);
    end
  endtask

  // One parent cycle: compare outputs for the edge just passed, then drive.
  task automatic tick(input logic nxt);
    @(negedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      if (rst) begin
        chk("R1", ch, phase[ch], 1'b0);
      end else begin
        string t;
        logic e;
        t = (tag != "") ? tag : ((exp_code[ch] == 2'd0) ? "R3" : "R4");
        e = (exp_code[ch] == 2'd0) ? ~hist[0] : hist[exp_code[ch]];
        chk(t, ch, phase[ch], e);
      end
    end
    if (!rst && hist[0] && !hist[1]) begin
      exp_code[0] = ctrl[9:8];    // R2 field positions
      exp_code[1] = ctrl[21:20];
    end
    mck = nxt;
  endtask

  task automatic run_div(input int ratio, input int periods);
    for (int p = 0; p < periods; p++)
      for (int c = 0; c < ratio; c++)
        tick(c < ratio / 2);
  endtask

  initial begin
    exp_code[0] = '0;
    exp_code[1] = '0;
    // R1: reset holds outputs low
    for (int i = 0; i < 5; i++) tick(1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R6: codes present but no module-clock rise yet -> inverted behaviour
    ctrl = mk_ctrl(2'd2, 2'd3, 1'b0);
    tag = "R6";
    for (int i = 0; i < 4; i++) tick(1'b0);
    tag = "";
    // Table of divide ratios and codes (fill=1 entries exercise R2)
    for (int v = 0; v < 10; v++) begin
      tag = VECS[v][0] ? "R2" : "";
      ctrl = mk_ctrl(VECS[v][4:3], VECS[v][2:1], VECS[v][0]);
      run_div(int'(VECS[v][12:5]), 6);
    end
    // R5: change codes in the middle of a module-clock high phase
    tag = "R5";
    ctrl = mk_ctrl(2'd1, 2'd1, 1'b0);
    run_div(8, 2);
    tick(1'b1); tick(1'b1);
    ctrl = mk_ctrl(2'd3, 2'd2, 1'b0);
    tick(1'b1); tick(1'b1);
    for (int i = 0; i < 4; i++) tick(1'b0);
    run_div(8, 2);
    // R7: only output 1's field changes; output 0 must be unaffected
    tag = "R7";
    ctrl = mk_ctrl(2'd2, 2'd0, 1'b0);
    run_div(6, 2);
    ctrl = mk_ctrl(2'd2, 2'd3, 1'b0);
    run_div(6, 3);
    // R1: reset again mid-operation
    tag = "";
    @(negedge clk);
    rst = 1'b1;
    mck = 1'b0;
    for (int i = 0; i < 4; i++) tick(1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule